// File: doc/BRIEF.md
# Hall-Sensor Commutation Gate Controller

This block turns the three Hall-effect position bits of a three-phase brushless motor into six gate-enable signals, one high-side and one low-side switch per phase of the power bridge. In each valid rotor position one phase sources current through its high-side switch, a second phase sinks it through its low-side switch, and the third phase floats. A direction input selects the rotation sense. An active-low brake input shorts the windings through the low-side switches. An active-low enable input lets an external PWM source chop the drive, and a chop request from an on-chip current regulator does the same.

While the drive is chopped off, the winding current recirculates through both low-side switches. This slow decay with synchronous rectification bypasses the body diode of the source phase's low-side switch. An overvoltage flag withholds that rectification. Fault flags from the supply, charge-pump and thermal monitors, and a latched locked-rotor flag, all arrive already combined into one digital flag, and that flag forces every gate off. Each half-bridge enforces a programmable dead time, counted in clock cycles, before either of its switches turns on.

Top module: `bldc_gate_ctrl`

## Requirements
- R1: With `dirFwd`=1, the Hall code {C,B,A} (hallIn[2]=C, hallIn[1]=B, hallIn[0]=A; phase index 0=A, 1=B, 2=C) selects a source phase and a sink phase as follows: 1 gives A/B, 3 gives A/C, 2 gives B/C, 6 gives B/A, 4 gives C/A, 5 gives C/B. In drive, the high-side gate of the source phase and the low-side gate of the sink phase are on, and every other gate is off.
- R2: With `dirFwd`=0, each valid code swaps the source and sink phases of R1, so the motor steps through the six states in reverse order.
- R3: The Hall codes 0 and 7 turn all six gates off unless brake is active.
- R4: With `brakeN`=0, all three low-side gates are on and all high-side gates are off, regardless of Hall code, enable, chop request, fault or overvoltage.
- R5: When `enableN`=1 or `chopReq`=1 (off period), without brake or fault and with a valid code, the source high-side gate is off. Both the sink low-side gate and the source phase's low-side gate are on, which gives slow decay with synchronous rectification.
- R6: With `overVolt`=1 during an off period, only the sink low-side gate is on. `overVolt` has no effect during drive.
- R7: With `faultIn`=1 and `brakeN`=1, all six gates are off from the first clock edge.
- R8: Reset clears all gates. A gate turns on only after both gates of its half-bridge have been off for at least `deadCycles`+1 consecutive cycles. A gate whose request drops turns off at the next clock edge.
- R9: The high-side and low-side gates of one phase are never on together, and at most one high-side gate is on.
- R10: The Hall bits pass through a two-flop synchronizer, so a gate turns off at the third clock edge after a Hall change. All other inputs act at the first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| deadCycles | input | DEAD_W | Dead time in clock cycles, minus one |
| hallIn | input | 3 | Hall bits: [0]=A, [1]=B, [2]=C (asynchronous) |
| dirFwd | input | 1 | 1 = forward sequence, 0 = reverse |
| brakeN | input | 1 | Active-low brake |
| enableN | input | 1 | Active-low enable; high chops the drive off |
| chopReq | input | 1 | Off-time request from the current regulator |
| faultIn | input | 1 | Combined fault flag; forces gates off |
| overVolt | input | 1 | Supply overvoltage; disables synchronous rectification |
| gateHi | output | 3 | High-side gate enables, one per phase |
| gateLo | output | 3 | Low-side gate enables, one per phase |

## Verification
A wrong entry in the decode table or a wrong mode priority shows up as a wrong gate pattern that stays in place. The bench samples each input combination once all counters have settled, so the fault is seen within a few cycles of the stimulus. A dead-time counter that is off by one, or that fails to restart, moves the turn-on of a low-side gate by one edge. The edge-by-edge timing checks catch that, and the checker's independent idle-run counter catches it on every turn-on. A synchronizer of the wrong depth shifts the Hall response to the second or fourth edge, which the latency check detects.

// File: rtl/bgc_pkg.sv
package bgc_pkg;
  localparam int PHASES = 3;

  typedef struct packed {
    logic [PHASES-1:0] hiReq;
    logic [PHASES-1:0] loReq;
  } gate_req_t;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_BRAKE = 2'd1,
    MODE_DRIVE = 2'd2,
    MODE_DECAY = 2'd3
  } drive_mode_t;
endpackage

// File: rtl/bgc_control.sv
module bgc_control
  import bgc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PHASES-1:0] hallIn,
  input  logic              dirFwd,
  input  logic              brakeN,
  input  logic              enableN,
  input  logic              chopReq,
  input  logic              faultIn,
  input  logic              overVolt,
  output gate_req_t         gateReq
);
  localparam int LAST = SYNC_STAGES - 1;

  // Hall synchronizer (R10)
  logic [SYNC_STAGES-1:0][PHASES-1:0] syncQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], hallIn};
  end

  logic [PHASES-1:0] hallNow;
  assign hallNow = syncQ[LAST];

  // forward decode table (R1, R3)
  logic       codeValid;
  logic [1:0] fwdSrc, fwdSnk;
  always_comb begin
    codeValid = 1'b1;
    fwdSrc    = 2'd0;
    fwdSnk    = 2'd0;
    unique case (hallNow)
      3'd1: begin fwdSrc = 2'd0; fwdSnk = 2'd1; end
      3'd3: begin fwdSrc = 2'd0; fwdSnk = 2'd2; end
      3'd2: begin fwdSrc = 2'd1; fwdSnk = 2'd2; end
      3'd6: begin fwdSrc = 2'd1; fwdSnk = 2'd0; end
      3'd4: begin fwdSrc = 2'd2; fwdSnk = 2'd0; end
      3'd5: begin fwdSrc = 2'd2; fwdSnk = 2'd1; end
      default: codeValid = 1'b0;
    endcase
  end

  // direction swap (R2)
  logic [1:0] srcPh, snkPh;
  assign srcPh = dirFwd ? fwdSrc : fwdSnk;
  assign snkPh = dirFwd ? fwdSnk : fwdSrc;

  logic [PHASES-1:0] srcMask, snkMask;
  assign srcMask = PHASES'(1) << srcPh;
  assign snkMask = PHASES'(1) << snkPh;

  // mode priority: brake > fault/invalid > chop > drive (R4, R7, R5)
  drive_mode_t mode;
  always_comb begin
    if (!brakeN)                    mode = MODE_BRAKE;
    else if (faultIn || !codeValid) mode = MODE_IDLE;
    else if (enableN || chopReq)    mode = MODE_DECAY;
    else                            mode = MODE_DRIVE;
  end

  always_comb begin
    gateReq = '0;
    unique case (mode)
      MODE_BRAKE: gateReq.loReq = '1;
      MODE_DRIVE: begin
        gateReq.hiReq = srcMask;
        gateReq.loReq = snkMask;
      end
      MODE_DECAY: gateReq.loReq = overVolt ? snkMask : (snkMask | srcMask); // R5, R6
      default:    gateReq = '0;
    endcase
  end
endmodule

// File: rtl/bgc_datapath.sv
module bgc_datapath
  import bgc_pkg::*;
#(
  parameter int DEAD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DEAD_W-1:0] deadCycles,
  input  gate_req_t         gateReq,
  output logic [PHASES-1:0] gateHi,
  output logic [PHASES-1:0] gateLo
);
  localparam logic [DEAD_W-1:0] CNT_MAX = '1;

  for (genvar p = 0; p < PHASES; p++) begin : g_leg
    logic              hiQ, loQ;
    logic [DEAD_W-1:0] idleCnt;
    logic              hiR, loR, anyOn, ready;

    assign hiR   = gateReq.hiReq[p];
    assign loR   = gateReq.loReq[p] & ~gateReq.hiReq[p];
    assign anyOn = hiQ | loQ;
    assign ready = (idleCnt >= deadCycles);

    // break immediately, make only after the idle run (R8)
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hiQ     <= 1'b0;
        loQ     <= 1'b0;
        idleCnt <= '0;
      end else if (anyOn) begin
        hiQ     <= hiQ & hiR;
        loQ     <= loQ & loR;
        idleCnt <= '0;
      end else if (ready && (hiR || loR)) begin
        hiQ <= hiR;
        loQ <= loR;
      end else if (idleCnt != CNT_MAX) begin
        idleCnt <= idleCnt + 1'b1;
      end
    end

    assign gateHi[p] = hiQ;
    assign gateLo[p] = loQ;
  end
endmodule

// File: rtl/bldc_gate_ctrl.sv
module bldc_gate_ctrl
  import bgc_pkg::*;
#(
  parameter int DEAD_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DEAD_W-1:0] deadCycles,
  input  logic [2:0]        hallIn,
  input  logic              dirFwd,
  input  logic              brakeN,
  input  logic              enableN,
  input  logic              chopReq,
  input  logic              faultIn,
  input  logic              overVolt,
  output logic [2:0]        gateHi,
  output logic [2:0]        gateLo
);
  gate_req_t gateReq;

  bgc_control #(.SYNC_STAGES(SYNC_STAGES)) u_control (
    .clk(clk), .rstN(rstN), .hallIn(hallIn), .dirFwd(dirFwd),
    .brakeN(brakeN), .enableN(enableN), .chopReq(chopReq),
    .faultIn(faultIn), .overVolt(overVolt), .gateReq(gateReq)
  );

  bgc_datapath #(.DEAD_W(DEAD_W)) u_datapath (
    .clk(clk), .rstN(rstN), .deadCycles(deadCycles),
    .gateReq(gateReq), .gateHi(gateHi), .gateLo(gateLo)
  );
endmodule

// File: rtl/bgc_checker.sv
module bgc_checker #(
  parameter int DEAD_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [DEAD_W-1:0] deadCycles,
  input logic              brakeN,
  input logic              faultIn,
  input logic              overVolt,
  input logic [2:0]        gateHi,
  input logic [2:0]        gateLo
);
  localparam int RUN_W = DEAD_W + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  a_r9_one_high: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gateHi));

  a_r4_brake_highs_off: assert property (@(posedge clk) disable iff (!rstN)
    !brakeN |=> (gateHi == 3'b000));

  a_r7_fault_all_off: assert property (@(posedge clk) disable iff (!rstN)
    (faultIn && brakeN) |=> (gateHi == 3'b000 && gateLo == 3'b000));

  a_r6_ov_single_low: assert property (@(posedge clk) disable iff (!rstN)
    (overVolt && brakeN) |=> ($countones(gateLo) <= 1));

  for (genvar p = 0; p < 3; p++) begin : g_ph
    logic [RUN_W-1:0] offRun;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                      offRun <= '0;
      else if (gateHi[p] || gateLo[p]) offRun <= '0;
      else if (offRun != RUN_MAX)     offRun <= offRun + 1'b1;
    end

    a_r9_no_shoot: assert property (@(posedge clk) disable iff (!rstN)
      !(gateHi[p] && gateLo[p]));

    a_r8_dead_time: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(gateHi[p]) || $rose(gateLo[p])) |-> (offRun > RUN_W'(deadCycles)));
  end
endmodule

bind bldc_gate_ctrl bgc_checker #(.DEAD_W(DEAD_W)) u_checker (
  .clk(clk), .rstN(rstN), .deadCycles(deadCycles), .brakeN(brakeN),
  .faultIn(faultIn), .overVolt(overVolt), .gateHi(gateHi), .gateLo(gateLo)
);

// File: tb/bldc_gate_ctrl_bench.sv
module bldc_gate_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEAD_W     = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DEAD_W-1:0] deadCycles = '0;
  logic [2:0]        hallIn = 3'd1;
  logic              dirFwd = 1'b1, brakeN = 1'b1, enableN = 1'b0;
  logic              chopReq = 1'b0, faultIn = 1'b0, overVolt = 1'b0;
  logic [2:0]        gateHi, gateLo;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bldc_gate_ctrl #(.DEAD_W(DEAD_W)) u_bldc_gate_ctrl (
    .clk(clk), .rstN(rstN), .deadCycles(deadCycles), .hallIn(hallIn),
    .dirFwd(dirFwd), .brakeN(brakeN), .enableN(enableN), .chopReq(chopReq),
    .faultIn(faultIn), .overVolt(overVolt), .gateHi(gateHi), .gateLo(gateLo)
  );

  task automatic checkEq(input string tag, input logic [5:0] act, input logic [5:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual hi/lo=%b expected %b (hall=%0d dir=%b brk=%b en=%b chop=%b flt=%b ov=%b dead=%0d)",
               tag, act, exp, hallIn, dirFwd, brakeN, enableN, chopReq, faultIn, overVolt, deadCycles);
    end
  endtask

  // expected gates from the requirement text
  function automatic logic [5:0] expGates(input logic [2:0] h, input logic d, input logic bk,
                                          input logic en, input logic ch, input logic f, input logic ov);
    int s, k, t;
    logic [2:0] hi, lo;
    s = -1; k = -1;
    case (h)
      3'd1: begin s = 0; k = 1; end
      3'd3: begin s = 0; k = 2; end
      3'd2: begin s = 1; k = 2; end
      3'd6: begin s = 1; k = 0; end
      3'd4: begin s = 2; k = 0; end
      3'd5: begin s = 2; k = 1; end
      default: ;
    endcase
    hi = 3'b000; lo = 3'b000;
    if (!bk) lo = 3'b111;
    else if (f || s < 0) lo = 3'b000;
    else begin
      if (!d) begin t = s; s = k; k = t; end
      if (!en && !ch) begin hi[s] = 1'b1; lo[k] = 1'b1; end
      else begin lo[k] = 1'b1; if (!ov) lo[s] = 1'b1; end
    end
    return {hi, lo};
  endfunction

  function automatic string tagFor(input logic [2:0] h, input logic d, input logic bk,
                                   input logic en, input logic ch, input logic f, input logic ov);
    if (!bk) return "R4 brake";
    if (f) return "R7 fault";
    if (h == 3'd0 || h == 3'd7) return "R3 invalid code";
    if (en || ch) return ov ? "R6 no rectification" : "R5 slow decay";
    if (ov) return "R6 ov ignored in drive";
    return d ? "R1 forward" : "R2 reverse";
  endfunction

  task automatic doReset(input int d);
    @(negedge clk);
    rstN = 1'b0;
    deadCycles = DEAD_W'(d);
    repeat (3) @(negedge clk);
    checkEq("R8 reset clears gates", {gateHi, gateLo}, 6'b0);
    rstN = 1'b1;
  endtask

  task automatic setIn(input logic [2:0] h, input logic d, input logic bk, input logic en,
                       input logic ch, input logic f, input logic ov);
    hallIn = h; dirFwd = d; brakeN = bk; enableN = en; chopReq = ch; faultIn = f; overVolt = ov;
  endtask

  initial begin
    int deadList[3] = '{0, 2, 5};
    foreach (deadList[i]) begin
      int d;
      d = deadList[i];
      setIn(3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      doReset(d);
      repeat (d + 10) @(negedge clk);
      checkEq("R1 steady drive A/B", {gateHi, gateLo}, 6'b001_010);

      // R8 dead time on phase A: chop off the source
      enableN = 1'b1;
      @(negedge clk);
      checkEq("R8 high-side off at first edge", {gateHi, gateLo[0]}, 4'b0000);
      for (int k = 2; k <= d + 1; k++) @(negedge clk);
      checkEq("R8 low-side still off inside dead time", {3'b000, gateLo[0]}, 4'b0000);
      @(negedge clk);
      checkEq("R8 low-side on after dead time", {3'b000, gateLo[0]}, 4'b0001);

      // R10 Hall latency: A/B -> A/C
      enableN = 1'b0;
      repeat (d + 10) @(negedge clk);
      hallIn = 3'd3;
      repeat (2) @(negedge clk);
      checkEq("R10 no change before third edge", {gateHi, gateLo}, 6'b001_010);
      @(negedge clk);
      checkEq("R10 change at third edge", {gateHi, gateLo}, 6'b001_100);

      // R7 fault acts at first edge
      repeat (d + 10) @(negedge clk);
      faultIn = 1'b1;
      @(negedge clk);
      checkEq("R7 fault off at first edge", {gateHi, gateLo}, 6'b0);
      faultIn = 1'b0;

      // sweep
      for (int dr = 0; dr < 2; dr++) begin
        for (int h = 0; h < 8; h++) begin
          for (int c = 0; c < 32; c++) begin
            logic bk, en, ch, f, ov;
            {bk, en, ch, f, ov} = 5'(c);
            setIn(3'(h), dr[0], bk, en, ch, f, ov);
            repeat (d + 8) @(negedge clk);
            checkEq(tagFor(3'(h), dr[0], bk, en, ch, f, ov), {gateHi, gateLo},
                    expGates(3'(h), dr[0], bk, en, ch, f, ov));
            checkEq("R9 no shoot-through", {3'b000, |(gateHi & gateLo), 2'b00}, 6'b0);
          end
        end
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule